// File: doc/BRIEF.md
# Move-Only Transport Processor Core

This core runs programs that have exactly one kind of instruction: a move that copies a value into a destination port. Every side effect comes from the destination written. The destinations select the ALU function, load either ALU operand, set the data address, store a word to memory, redirect the program counter, or stop the machine. The value moved is either a sign-extended 6-bit immediate or one of three readable sources: the memory word at the data address, the ALU result, or the address of the current instruction.

Instructions and data share one synchronous, word-addressed memory with a single port. The memory sits outside the core. Each move takes three clock cycles: fetch, operand load and execute. Constants too wide for an immediate are stored inline and reached through a PC-relative address computed in the ALU. Branches are made by moving an ALU result into the jump port. A program can emulate a register machine by keeping its registers at low memory addresses.

Top module: `xfer_core`

## Requirements
- R1: An instruction is a 16-bit word. Bits 15:12 hold the destination code and bits 11:8 the source code. Bit 6 set means the move carries the immediate in bits 5:0; clear means it carries the selected source. Bit 7 is ignored.
- R2: The ALU function register selects ADD=0 (A+B), SUB=1 (A-B) and SEQ=2 (1 when A equals B, else 0), with code 3 giving 0. The ALU result source (code 1) always reflects the current A, B and function registers.
- R3: An immediate is treated as 6-bit two's complement (-32..31) and sign-extended to the full data width before it reaches any destination.
- R4: After a move into the data-address destination (code 3), a later move from the memory source (code 0) returns the word stored at that address.
- R5: A move into the store destination (code 4) writes the moved value to the address held in the data-address register. memWrEn is asserted only in that execute cycle, and memAddr then equals the data address.
- R6: The PC source (code 2) returns the address of the move that reads it, zero-extended, so PC-relative offsets are counted from that move.
- R7: Every move takes exactly three cycles. When the move does not target the jump port, the next fetch address is the current one plus one.
- R8: A move into the jump destination (code 5) makes its value, truncated to the address width, the next fetch address.
- R9: A move into the stop destination (code 15) raises halted one execute cycle later. From then on no fetch, write or address change occurs until reset.
- R10: Destination codes 6 to 14 change no state. Source codes 3 to 15 read as zero.
- R11: While rstN is low, the PC, operand registers, data address and function register are zero, memAddr is 0, memWrEn is 0 and halted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | AW | Word address to shared memory |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | DW | Data to be written |
| memRdData | input | DW | Word read one cycle after its address |
| halted | output | 1 | Core has executed a stop move |

## Verification
The bench builds the core with its defaults, DW=16 and AW=8. These values let sign extension show up as full 16-bit words (0xFFC1, 0xFFFF) and keep the data addresses (20 to 30) reachable by plain immediates. They also let a 256-word memory model in the bench hold every program, its inline constants and its results. The settings cover all four ALU codes, a PC-relative load of an inline constant, a forward jump past a stop move, the cycle count per move, and the frozen state after stopping.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int INSN_W = 16;
  localparam int IMM_W  = 6;

  // destination codes
  localparam logic [3:0] DST_AOP   = 4'd0;
  localparam logic [3:0] DST_A     = 4'd1;
  localparam logic [3:0] DST_B     = 4'd2;
  localparam logic [3:0] DST_ADDR  = 4'd3;
  localparam logic [3:0] DST_WRITE = 4'd4;
  localparam logic [3:0] DST_NPC   = 4'd5;
  localparam logic [3:0] DST_HALT  = 4'd15;

  // source codes
  localparam logic [3:0] SRC_READ  = 4'd0;
  localparam logic [3:0] SRC_AOUT  = 4'd1;
  localparam logic [3:0] SRC_PC    = 4'd2;

  // ALU function codes
  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_SUB = 2'd1;
  localparam logic [1:0] OP_SEQ = 2'd2;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_LOAD  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  typedef struct packed {
    logic latchIr;   // capture instruction word from memory
    logic execute;   // perform the move this cycle
    logic dataPort;  // memory address comes from the data address register
  } strobe_t;

endpackage

// File: rtl/xfer_alu.sv
module xfer_alu
  import xfer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    opSel,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] result
);

  always_comb begin
    unique case (opSel)
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_SEQ:  result = DW'(opA == opB);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    haltReq,
  output strobe_t stb,
  output logic    halted
);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_FETCH;
    end else begin
      unique case (phase)
        PH_FETCH: phase <= PH_LOAD;
        PH_LOAD:  phase <= PH_EXEC;
        PH_EXEC:  phase <= haltReq ? PH_STOP : PH_FETCH;
        default:  phase <= PH_STOP;
      endcase
    end
  end

  always_comb begin
    stb.latchIr  = (phase == PH_LOAD);
    stb.execute  = (phase == PH_EXEC);
    stb.dataPort = (phase == PH_LOAD) || (phase == PH_EXEC);
    halted       = (phase == PH_STOP);
  end

  AST_FETCH_THEN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_FETCH |=> phase == PH_LOAD); // R7
  AST_LOAD_THEN_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_LOAD |=> phase == PH_EXEC); // R7
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !stb.execute && !stb.latchIr); // R9

endmodule

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] memRdData,
  output logic [AW-1:0] memAddr,
  output logic          memWrEn,
  output logic [DW-1:0] memWrData,
  output logic          haltReq
);

  localparam int PAD_W = DW - AW;
  localparam int EXT_W = DW - IMM_W;

  logic [3:0]       irDst;
  logic [3:0]       irSrc;
  logic             irUseImm;
  logic [IMM_W-1:0] irImm;

  logic [AW-1:0] pc;
  logic [AW-1:0] addrReg;
  logic [1:0]    aop;
  logic [DW-1:0] aReg;
  logic [DW-1:0] bReg;
  logic [DW-1:0] aout;
  logic [DW-1:0] srcVal;
  logic [DW-1:0] immExt;
  logic [DW-1:0] moveVal;

  xfer_alu #(.DW(DW)) u_alu (
    .opSel (aop),
    .opA   (aReg),
    .opB   (bReg),
    .result(aout)
  );

  always_comb begin
    unique case (irSrc)
      SRC_READ: srcVal = memRdData;
      SRC_AOUT: srcVal = aout;
      SRC_PC:   srcVal = {{PAD_W{1'b0}}, pc};
      default:  srcVal = '0;
    endcase
    immExt  = {{EXT_W{irImm[IMM_W-1]}}, irImm};
    moveVal = irUseImm ? immExt : srcVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irDst    <= '0;
      irSrc    <= '0;
      irUseImm <= 1'b0;
      irImm    <= '0;
      pc       <= '0;
      addrReg  <= '0;
      aop      <= OP_ADD;
      aReg     <= '0;
      bReg     <= '0;
    end else begin
      if (stb.latchIr) begin
        irDst    <= memRdData[15:12];
        irSrc    <= memRdData[11:8];
        irUseImm <= memRdData[6];
        irImm    <= memRdData[IMM_W-1:0];
      end
      if (stb.execute) begin
        unique case (irDst)
          DST_AOP:  aop     <= moveVal[1:0];
          DST_A:    aReg    <= moveVal;
          DST_B:    bReg    <= moveVal;
          DST_ADDR: addrReg <= moveVal[AW-1:0];
          default:  ;
        endcase
        if (irDst == DST_NPC) begin
          pc <= moveVal[AW-1:0];
        end else if (irDst != DST_HALT) begin
          pc <= pc + AW'(1);
        end
      end
    end
  end

  always_comb begin
    memAddr   = stb.dataPort ? addrReg : pc;
    memWrEn   = stb.execute && (irDst == DST_WRITE);
    memWrData = moveVal;
    haltReq   = (irDst == DST_HALT);
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.execute && irDst != DST_NPC && irDst != DST_HALT
      |=> pc == AW'($past(pc) + AW'(1))); // R7
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    stb.execute && irDst == DST_NPC |=> pc == $past(moveVal[AW-1:0])); // R8
  AST_STORE_AT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memAddr == addrReg && stb.execute); // R5
  AST_SEQ_IS_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    aop == OP_SEQ |-> aout <= DW'(1)); // R2
  AST_IDLE_DEST_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    stb.execute && irDst > DST_NPC && irDst != DST_HALT
      |=> $stable(aReg) && $stable(bReg) && $stable(addrReg) && $stable(aop)); // R10

endmodule

// File: rtl/xfer_core.sv
module xfer_core
  import xfer_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [AW-1:0] memAddr,
  output logic          memWrEn,
  output logic [DW-1:0] memWrData,
  input  logic [DW-1:0] memRdData,
  output logic          halted
);

  strobe_t stb;
  logic    haltReq;

  xfer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .haltReq(haltReq),
    .stb    (stb),
    .halted (halted)
  );

  xfer_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .haltReq  (haltReq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !memWrEn); // R11

endmodule

// File: tb/xfer_core_bench.sv
module xfer_core_bench;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memWrEn;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData = '0;
  logic          halted;
  logic [DW-1:0] mem [DEPTH];

  int runCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xfer_core #(.DW(DW), .AW(AW)) u_xfer_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
  end

  // a[33:28] b[27:22] op[21:16] expected[15:0]
  localparam logic [33:0] VECS [8] = '{
    {6'h20, 6'h1F, 6'd0, 16'hFFFF},
    {6'h1F, 6'h1F, 6'd0, 16'h003E},
    {6'h20, 6'h1F, 6'd1, 16'hFFC1},
    {6'h03, 6'h07, 6'd1, 16'hFFFC},
    {6'h05, 6'h05, 6'd2, 16'h0001},
    {6'h05, 6'h06, 6'd2, 16'h0000},
    {6'h3F, 6'h3F, 6'd2, 16'h0001},
    {6'h04, 6'h04, 6'd3, 16'h0000}
  };

  function automatic logic [15:0] mvi(input logic [3:0] d, input logic [5:0] v);
    return {d, 4'd0, 1'b0, 1'b1, v};
  endfunction

  function automatic logic [15:0] mvr(input logic [3:0] d, input logic [3:0] s);
    return {d, s, 8'd0};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic runIt(output int cycles);
    cycles = 0;
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (halted) break;
    end
    check("R9 halted reached", DW'(halted), DW'(1));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [AW-1:0] frozenAddr;
    clearMem();
    repeat (3) @(negedge clk);
    check("R11 memAddr in reset", DW'(memAddr), 16'd0);
    check("R11 memWrEn in reset", DW'(memWrEn), 16'd0);
    check("R11 halted in reset", DW'(halted), 16'd0);

    // R2 R3 R7: ALU table
    for (int v = 0; v < 8; v++) begin
      clearMem();
      mem[20] = 16'hDEAD;
      mem[0] = mvi(4'd0, VECS[v][21:16]);
      mem[1] = mvi(4'd1, VECS[v][33:28]);
      mem[2] = mvi(4'd2, VECS[v][27:22]);
      mem[3] = mvi(4'd3, 6'd20);
      mem[4] = mvr(4'd4, 4'd1);
      mem[5] = mvi(4'd15, 6'd0);
      runIt(cyc);
      check("R2 R3 ALU result", mem[20], VECS[v][15:0]);
      check("R7 three cycles per move", DW'(cyc), 16'd18);
    end

    // R4: read through data address
    clearMem();
    mem[30] = 16'h1234;
    mem[0] = mvi(4'd3, 6'd30);
    mem[1] = mvr(4'd1, 4'd0);
    mem[2] = mvi(4'd2, 6'd0);
    mem[3] = mvi(4'd3, 6'd21);
    mem[4] = mvr(4'd4, 4'd1);
    mem[5] = mvi(4'd15, 6'd0);
    runIt(cyc);
    check("R4 memory read", mem[21], 16'h1234);

    // R6: PC-relative inline constant
    clearMem();
    mem[0] = mvi(4'd0, 6'd0);
    mem[1] = mvr(4'd1, 4'd2);
    mem[2] = mvi(4'd2, 6'd8);
    mem[3] = mvr(4'd3, 4'd1);
    mem[4] = mvr(4'd1, 4'd0);
    mem[5] = mvi(4'd3, 6'd22);
    mem[6] = mvi(4'd2, 6'd0);
    mem[7] = mvr(4'd4, 4'd1);
    mem[8] = mvi(4'd15, 6'd0);
    mem[9] = 16'h7ABC;
    runIt(cyc);
    check("R6 inline constant", mem[22], 16'h7ABC);

    // R8 R5 R6: forward jump over a stop move
    clearMem();
    mem[0] = mvr(4'd1, 4'd2);
    mem[1] = mvi(4'd2, 6'd4);
    mem[2] = mvr(4'd5, 4'd1);
    mem[3] = mvi(4'd15, 6'd0);
    mem[4] = mvi(4'd3, 6'd23);
    mem[5] = mvi(4'd4, 6'd7);
    mem[6] = mvi(4'd3, 6'd24);
    mem[7] = mvr(4'd4, 4'd2);
    mem[8] = mvi(4'd15, 6'd0);
    runIt(cyc);
    check("R8 jump target executed", mem[23], 16'd7);
    check("R6 PC reads own address", mem[24], 16'd7);
    check("R7 cycles with jump", DW'(cyc), 16'd24);

    // R10 R1: unassigned codes, reserved bit 7
    clearMem();
    mem[0] = mvi(4'd3, 6'd25);
    mem[1] = mvi(4'd1, 6'd5) | 16'h0080;
    mem[2] = mvr(4'd2, 4'd7);
    mem[3] = mvi(4'd9, 6'd3);
    mem[4] = mvr(4'd4, 4'd1);
    mem[5] = mvi(4'd15, 6'd0);
    runIt(cyc);
    check("R10 R1 unused codes", mem[25], 16'd5);

    // R9: frozen after stop
    frozenAddr = memAddr;
    repeat (6) @(negedge clk);
    check("R9 still halted", DW'(halted), 16'd1);
    check("R9 address frozen", DW'(memAddr), DW'(frozenAddr));
    check("R9 no write", DW'(memWrEn), 16'd0);
    check("R9 memory untouched", mem[25], 16'd5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

endmodule